// File: doc/BRIEF.md
# Flag-Setting Arithmetic Unit with Condition Evaluator

This block is the arithmetic core of a simple 64-bit processor execute stage. It computes one of four two-operand operations on a pair of operands. The operation is chosen by a 4-bit operation code. The operation result is registered and appears one clock after the operands. When the flag-update enable is high, the block also captures three status flags derived from that operation: zero, negative and signed overflow.

A separate combinational evaluator compares a 4-bit condition selector against the stored flags. It returns a single take/move decision. Conditional register moves and conditional branches both use this decision, and both use the same seven-entry condition encoding. Operand selection, the register file and memory are outside this block.

Top module: `alu_cc_unit`

## Requirements
- R1: With op code 0 the registered result one clock later equals op_b + op_a, modulo 2^DATA_W.
- R2: With op code 1 the registered result one clock later equals op_b - op_a (second operand minus first), modulo 2^DATA_W.
- R3: With op code 2 the result is op_b AND op_a; with op code 3 it is op_b XOR op_a, one clock later.
- R4: On a clock edge with set_cc high and a valid op code, flag_z becomes 1 exactly when the new result is zero, and flag_s becomes the new result's top bit.
- R5: flag_o captures two's-complement overflow for add (operands share a sign that the sum does not) and for subtract (operand signs differ and the difference's sign differs from op_b); and and xor clear it.
- R6: On an edge with set_cc low, all three flags keep their values.
- R7: Synchronous active-high reset sets result to 0, flag_z to 1, flag_s to 0 and flag_o to 0.
- R8: cond_true for cond_fn 0..6 is: 0 always 1; 1 (lt or Z); 2 lt; 3 Z; 4 not Z; 5 not lt; 6 (not lt and not Z). Here lt = S xor O, and Z, S, O are the stored flags.
- R9: Any cond_fn from 7 to 15 gives cond_true = 0.
- R10: Op codes 4..15 give a registered result of 0 and leave the flags unchanged even when set_cc is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | DATA_W | First operand (subtrahend for subtract) |
| op_b | input | DATA_W | Second operand |
| alu_fn | input | 4 | Operation code: 0 add, 1 subtract, 2 and, 3 xor |
| set_cc | input | 1 | Flag capture enable for this cycle's operation |
| cond_fn | input | 4 | Condition selector, 0..6 valid |
| result | output | DATA_W | Registered operation result |
| flag_z | output | 1 | Stored zero flag |
| flag_s | output | 1 | Stored negative flag |
| flag_o | output | 1 | Stored signed overflow flag |
| cond_true | output | 1 | Condition decision from stored flags |

## Verification
The operations are exercised with small positive operands and with operands whose subtraction goes negative. Further cases cross the positive-maximum and negative-minimum boundaries, and others cancel to zero, so each flag is seen both set and clear. One vector adds two minimum negatives: it wraps to zero with overflow. The and operation that follows it shows that overflow is cleared rather than held. After every flag state, all sixteen condition selectors are checked. This tells the signed less-than terms apart from plain sign tests, and shows that the unused selectors stay false. Directed cases hold set_cc low, issue undefined op codes and assert reset in mid-run, to show the flags do not move.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_XOR = 4'd3
  } alu_fn_e;

  typedef enum logic [3:0] {
    CD_ALWAYS = 4'd0,
    CD_LE     = 4'd1,
    CD_LT     = 4'd2,
    CD_EQ     = 4'd3,
    CD_NE     = 4'd4,
    CD_GE     = 4'd5,
    CD_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } ccflags_t;

  localparam ccflags_t CC_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [3:0]        fn,
  output logic [DATA_W-1:0] res,
  output ccflags_t          flags_nxt,
  output logic              fn_ok
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] sum_w;
  logic [DATA_W-1:0] dif_w;
  logic              ovf_add;
  logic              ovf_sub;
  logic              ovf_sel;

  assign sum_w   = b + a;
  assign dif_w   = b - a;
  assign ovf_add = (a[MSB] == b[MSB]) && (sum_w[MSB] != b[MSB]);
  assign ovf_sub = (a[MSB] != b[MSB]) && (dif_w[MSB] != b[MSB]);

  always_comb begin
    res     = '0;
    ovf_sel = 1'b0;
    fn_ok   = 1'b1;
    case (fn)
      FN_ADD: begin res = sum_w; ovf_sel = ovf_add; end
      FN_SUB: begin res = dif_w; ovf_sel = ovf_sub; end
      FN_AND: res = b & a;
      FN_XOR: res = b ^ a;
      default: fn_ok = 1'b0;
    endcase
  end

  assign flags_nxt.zf = (res == '0);
  assign flags_nxt.sf = res[MSB];
  assign flags_nxt.of = ovf_sel;

endmodule

// File: rtl/alu_cc_flagreg.sv
module alu_cc_flagreg
  import alu_cc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  ccflags_t d,
  output ccflags_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= CC_RESET;
    else if (load) q <= d;
  end

  // R6: flags move only on a load
  assert_flag_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

endmodule

// File: rtl/alu_cc_condeval.sv
module alu_cc_condeval
  import alu_cc_pkg::*;
(
  input  ccflags_t   flags,
  input  logic [3:0] sel,
  output logic       take
);
  logic lt;
  assign lt = flags.sf ^ flags.of;

  always_comb begin
    case (sel)
      CD_ALWAYS: take = 1'b1;
      CD_LE:     take = lt | flags.zf;
      CD_LT:     take = lt;
      CD_EQ:     take = flags.zf;
      CD_NE:     take = ~flags.zf;
      CD_GE:     take = ~lt;
      CD_GT:     take = ~lt & ~flags.zf;
      default:   take = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [3:0]        alu_fn,
  input  logic              set_cc,
  input  logic [3:0]        cond_fn,
  output logic [DATA_W-1:0] result,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_o,
  output logic              cond_true
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] res_c;
  ccflags_t          flags_c;
  ccflags_t          flags_q;
  logic              fn_ok;

  alu_cc_datapath #(.DATA_W(DATA_W)) dp_i (
    .a(op_a), .b(op_b), .fn(alu_fn),
    .res(res_c), .flags_nxt(flags_c), .fn_ok(fn_ok)
  );

  alu_cc_flagreg fr_i (
    .clk(clk), .rst(rst), .load(set_cc & fn_ok),
    .d(flags_c), .q(flags_q)
  );

  alu_cc_condeval ce_i (
    .flags(flags_q), .sel(cond_fn), .take(cond_true)
  );

  always_ff @(posedge clk) begin
    if (rst) result <= '0;
    else     result <= res_c;
  end

  assign flag_z = flags_q.zf;
  assign flag_s = flags_q.sf;
  assign flag_o = flags_q.of;

  // R7: reset state
  assert_reset_state_R7: assert property (@(posedge clk)
    rst |=> (result == '0 && flag_z && !flag_s && !flag_o));

  // R1: add result one clock later
  assert_add_result_R1: assert property (@(posedge clk) disable iff (rst)
    (alu_fn == 4'd0) |=> (result == $past(op_b) + $past(op_a)));

  // R4: captured zero/sign agree with the registered result
  assert_flags_match_R4: assert property (@(posedge clk) disable iff (rst)
    (set_cc && alu_fn < 4'd4) |=> (flag_z == (result == '0) && flag_s == result[MSB]));

  // R5: logic operations clear overflow
  assert_logic_clears_of_R5: assert property (@(posedge clk) disable iff (rst)
    (set_cc && (alu_fn == 4'd2 || alu_fn == 4'd3)) |=> !flag_o);

  // R10: undefined op codes leave the flags alone
  assert_bad_fn_keeps_flags_R10: assert property (@(posedge clk) disable iff (rst)
    (alu_fn > 4'd3) |=> ($stable({flag_z, flag_s, flag_o}) && result == '0));

  // R8: equal selector follows zero flag
  assert_eq_follows_z_R8: assert property (@(posedge clk) disable iff (rst)
    (cond_fn == 4'd3) |-> (cond_true == flag_z));

  // R9: unused selectors are false
  assert_unused_cond_false_R9: assert property (@(posedge clk) disable iff (rst)
    (cond_fn > 4'd6) |-> !cond_true);

endmodule

// File: tb/alu_cc_unit_tb.sv
module alu_cc_unit_tb_top;
  localparam int W  = 64;
  localparam int NV = 12;
  localparam int VW = 4 + 3*W + 3;

  // {fn, a, b, expected result, expected {z,s,o}}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd0, 64'h3, 64'h5, 64'h8, 3'b000},
    {4'd0, 64'h1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 3'b011},
    {4'd0, 64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3'b100},
    {4'd1, 64'h3, 64'h5, 64'h2, 3'b000},
    {4'd1, 64'h5, 64'h3, 64'hFFFF_FFFF_FFFF_FFFE, 3'b010},
    {4'd1, 64'h1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 3'b001},
    {4'd1, 64'h1234, 64'h1234, 64'h0, 3'b100},
    {4'd2, 64'hFF00, 64'h0FF0, 64'h0F00, 3'b000},
    {4'd0, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h0, 3'b101},
    {4'd2, 64'hAAAA, 64'h5555, 64'h0, 3'b100},
    {4'd3, 64'h8000_0000_0000_0000, 64'h1, 64'h8000_0000_0000_0001, 3'b010},
    {4'd3, 64'hDEAD, 64'hDEAD, 64'h0, 3'b100}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic [3:0]   alu_fn = 4'd0;
  logic         set_cc = 1'b0;
  logic [3:0]   cond_fn = 4'd0;
  logic [W-1:0] result;
  logic         flag_z, flag_s, flag_o, cond_true;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  alu_cc_unit #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .alu_fn(alu_fn),
    .set_cc(set_cc), .cond_fn(cond_fn), .result(result),
    .flag_z(flag_z), .flag_s(flag_s), .flag_o(flag_o), .cond_true(cond_true)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic want_cond(input logic [3:0] c, input logic [2:0] zso);
    logic lt;
    lt = zso[1] ^ zso[0];
    case (c)
      4'd0: return 1'b1;
      4'd1: return lt | zso[2];
      4'd2: return lt;
      4'd3: return zso[2];
      4'd4: return !zso[2];
      4'd5: return !lt;
      4'd6: return !lt && !zso[2];
      default: return 1'b0;
    endcase
  endfunction

  // all sixteen selectors against the expected stored flags (R8, R9)
  task automatic sweep_cond(input logic [2:0] zso);
    for (int c = 0; c < 16; c++) begin
      @(negedge clk);
      cond_fn = 4'(c);
      #1;
      chk(c <= 6 ? "R8 cond" : "R9 cond", W'(cond_true), W'(want_cond(4'(c), zso)));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [3:0]   fn;
    logic [W-1:0] ea;
    logic [W-1:0] eb;
    logic [W-1:0] er;
    logic [2:0]   ef;

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7 reset result", result, '0);
    chk("R7 reset flags", W'({flag_z, flag_s, flag_o}), W'(3'b100));
    cond_fn = 4'd3; #1;
    chk("R8 eq after reset", W'(cond_true), W'(1'b1));
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      {fn, ea, eb, er, ef} = VEC[i];
      @(negedge clk);
      alu_fn = fn; op_a = ea; op_b = eb; set_cc = 1'b1;
      @(negedge clk);
      set_cc = 1'b0;
      chk(fn == 4'd0 ? "R1 add" : fn == 4'd1 ? "R2 sub" : "R3 logic", result, er);
      chk("R4 zero/sign", W'({flag_z, flag_s}), W'(ef[2:1]));
      chk("R5 overflow", W'(flag_o), W'(ef[0]));
      sweep_cond(ef);
    end

    // R6: set_cc low keeps flags (currently Z=1 S=0 O=0)
    @(negedge clk);
    alu_fn = 4'd1; op_a = 64'h9; op_b = 64'h2; set_cc = 1'b0;
    @(negedge clk);
    chk("R2 sub no capture", result, 64'hFFFF_FFFF_FFFF_FFF9);
    chk("R6 flags held", W'({flag_z, flag_s, flag_o}), W'(3'b100));

    // R10: undefined op codes with set_cc high
    @(negedge clk);
    alu_fn = 4'd9; op_a = 64'h5; op_b = 64'h7; set_cc = 1'b1;
    @(negedge clk);
    chk("R10 bad fn result", result, '0);
    chk("R10 bad fn flags", W'({flag_z, flag_s, flag_o}), W'(3'b100));
    alu_fn = 4'd4; op_a = 64'h8000_0000_0000_0000; op_b = 64'h1;
    @(negedge clk);
    chk("R10 fn4 result", result, '0);
    chk("R10 fn4 flags", W'({flag_z, flag_s, flag_o}), W'(3'b100));

    // set a non-reset flag state, then reset mid-run (R7)
    alu_fn = 4'd1; op_a = 64'h1; op_b = 64'h8000_0000_0000_0000;
    @(negedge clk);
    set_cc = 1'b0;
    chk("R5 sub overflow", W'({flag_z, flag_s, flag_o}), W'(3'b001));
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R7 mid reset result", result, '0);
    chk("R7 mid reset flags", W'({flag_z, flag_s, flag_o}), W'(3'b100));

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule